// File: doc/BRIEF.md
# ATM Flow-Status Cell Marker

This block sits in the cell path of an ATM switch port and decides, one cell at a time, whether a passing cell should carry a congestion mark. Each cell comes with a valid strobe and a set of side inputs: its 32-bit header without the HEC, the switch overhead word that travels with it, the cell's direction (ingress or egress), a cell-kind code, the connection number, and the byte of the RM payload that holds the CI and NI flags. The marked header and payload byte leave the block one clock later.

There are two flow status signals. The ingress flow status is true when any of three sources is true. The first is a global mark enable. The second is a status bit taken from the overhead word at a byte and bit position chosen by software. That bit counts only for egress cells, and only when the overhead path is enabled and the egress qualifier is set. The third is a per-connection bit stored in a 16-entry context. Egress cells write this bit from the overhead, and it counts only for ingress cells, and only when the ingress qualifier is set. The egress flow status is true when a global egress enable is set, or when a second overhead bit at its own programmable position is set and enabled on an egress cell. The flow status then selects what gets marked: CI and/or NI on egress backward RM cells or on ingress forward RM cells, and EFCI on user data cells.

Top module: `atm_flow_marker`

## Requirements
- R1: After reset `out_vld`, `out_hdr` and `out_rmb` are 0, and every stored per-connection status bit is 0. A cleared bit means an ingress forward RM cell that relies only on its context bit leaves unmarked.
- R2: `out_vld` is high in exactly the cycle after the edge that accepted a cell with `cell_vld` high. `out_hdr` and `out_rmb` then show that cell's marked header and payload byte.
- R3: When `cfg_glb_ing_mark` is 1, an ingress forward RM cell is marked if `cfg_frm_mark_en` is 1. Marking sets bit CI_BIT (default 6) of the payload byte when `cfg_set_ci` is 1, and bit NI_BIT (default 5) when `cfg_set_ni` is 1. A forward RM cell has `cell_type` 2'b01.
- R4: An egress backward RM cell (`cell_type` 2'b10) is marked when `cfg_brm_mark_en` is 1 and the overhead bit at index 8*`cfg_ifs_byte`+`cfg_ifs_bit` is 1, provided `cfg_ovh_en` and `cfg_ovh_sel_egr` are both 1. A 1 at any other overhead position has no effect, and the overhead path never marks an ingress cell.
- R5: An accepted egress cell writes the selected overhead status bit into the context entry of its connection when `cfg_ovh_en` is 1. A later ingress forward RM cell on that connection is then marked when `cfg_ctx_sel_ing`, `cfg_ovh_en` and `cfg_frm_mark_en` are 1. Cells on other connections are unaffected.
- R6: A later egress cell on the same connection whose selected overhead bit is 0 clears that connection's stored bit.
- R7: EFCI marking applies only to user data cells: `cell_type` 2'b00 with header bit 3 (the top PTI bit) equal to 0. It sets header bit 2 and leaves all other header bits unchanged. It occurs when `cfg_efci_en` is 1 and the flow status for the cell's direction is 1. A cell whose header bit 3 is 1 leaves with an unchanged header.
- R8: An RM marking needs the header PTI field (bits 3:1) to equal 3'b110. A cell with an RM `cell_type` but any other PTI leaves with an unchanged payload byte.
- R9: CI and NI are only ever set, never cleared. Payload bits that are already 1 stay 1, and bits other than CI_BIT and NI_BIT pass unchanged.
- R10: On egress data cells the egress flow status drives EFCI. That status is true when `cfg_glb_egr_mark` is 1, or when `cfg_efs_en` is 1 and the overhead bit at 8*`cfg_efs_byte`+`cfg_efs_bit` is 1.
- R11: With `cfg_ovh_en` at 0, neither the overhead path nor the stored context marks any cell, and egress cells do not update the context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_vld | input | 1 | Cell present this cycle |
| cell_egress | input | 1 | 1 = egress cell, 0 = ingress cell |
| cell_type | input | 2 | 00 data, 01 forward RM, 10 backward RM, 11 other |
| cell_conn | input | CONN_W (4) | Connection number |
| cell_hdr | input | 32 | Cell header without HEC, PTI at bits 3:1 |
| cell_ovh | input | OVH_W (32) | Switch overhead word |
| cell_rmb | input | 8 | RM payload byte holding CI and NI |
| cfg_glb_ing_mark | input | 1 | Global ingress mark enable |
| cfg_ovh_en | input | 1 | Enable for overhead status and context paths |
| cfg_ovh_sel_egr | input | 1 | Overhead bit counts on egress cells |
| cfg_ctx_sel_ing | input | 1 | Stored bit counts on ingress cells |
| cfg_glb_egr_mark | input | 1 | Global egress mark enable |
| cfg_efs_en | input | 1 | Enable for the overhead egress status bit |
| cfg_brm_mark_en | input | 1 | Mark egress backward RM cells on ingress status |
| cfg_frm_mark_en | input | 1 | Mark ingress forward RM cells on ingress status |
| cfg_efci_en | input | 1 | EFCI marking of user data cells |
| cfg_set_ci | input | 1 | RM marking sets CI |
| cfg_set_ni | input | 1 | RM marking sets NI |
| cfg_ifs_byte | input | BSEL_W (2) | Byte of the ingress status bit in the overhead |
| cfg_ifs_bit | input | 3 | Bit of the ingress status bit within its byte |
| cfg_efs_byte | input | BSEL_W (2) | Byte of the egress status bit in the overhead |
| cfg_efs_bit | input | 3 | Bit of the egress status bit within its byte |
| out_vld | output | 1 | Marked cell present |
| out_hdr | output | 32 | Header after EFCI marking |
| out_rmb | output | 8 | RM payload byte after CI/NI marking |

## Verification
A wrong stored context bit shows at the ports only when a later ingress forward RM cell arrives on that connection with the context path enabled. That cell's CI bit is then wrong one cycle after it is accepted. The bench therefore writes a connection's bit and probes it with such a cell. It also probes a neighbouring connection and probes again after the bit is cleared. A wrong bit-position decode shows one cycle later as a missing or a spurious mark. The bench places the status bit at the selected position and also at positions next to it.

// File: rtl/atm_flow_marker.sv
module atm_flow_marker #(
  parameter int N_CONN    = 16,
  parameter int OVH_BYTES = 4,
  parameter int CI_BIT    = 6,
  parameter int NI_BIT    = 5,
  localparam int CONN_W   = $clog2(N_CONN),
  localparam int OVH_W    = OVH_BYTES * 8,
  localparam int BSEL_W   = $clog2(OVH_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_vld,
  input  logic              cell_egress,
  input  logic [1:0]        cell_type,
  input  logic [CONN_W-1:0] cell_conn,
  input  logic [31:0]       cell_hdr,
  input  logic [OVH_W-1:0]  cell_ovh,
  input  logic [7:0]        cell_rmb,
  input  logic              cfg_glb_ing_mark,
  input  logic              cfg_ovh_en,
  input  logic              cfg_ovh_sel_egr,
  input  logic              cfg_ctx_sel_ing,
  input  logic              cfg_glb_egr_mark,
  input  logic              cfg_efs_en,
  input  logic              cfg_brm_mark_en,
  input  logic              cfg_frm_mark_en,
  input  logic              cfg_efci_en,
  input  logic              cfg_set_ci,
  input  logic              cfg_set_ni,
  input  logic [BSEL_W-1:0] cfg_ifs_byte,
  input  logic [2:0]        cfg_ifs_bit,
  input  logic [BSEL_W-1:0] cfg_efs_byte,
  input  logic [2:0]        cfg_efs_bit,
  output logic              out_vld,
  output logic [31:0]       out_hdr,
  output logic [7:0]        out_rmb
);

  logic [N_CONN-1:0] ctx_q;

  logic ovh_ifs, ovh_efs;
  logic is_rm_pti, is_user;
  logic ifs_path, ctx_path, ing_status, egr_status;
  logic mark_brm, mark_frm, mark_rm, mark_efci;
  logic [7:0] rm_set;

  assign ovh_ifs = cell_ovh[{cfg_ifs_byte, cfg_ifs_bit}];
  assign ovh_efs = cell_ovh[{cfg_efs_byte, cfg_efs_bit}];

  assign is_rm_pti = (cell_hdr[3:1] == 3'b110);
  assign is_user   = (cell_type == 2'b00) && !cell_hdr[3];

  assign ifs_path   = ovh_ifs & cfg_ovh_en & cfg_ovh_sel_egr & cell_egress;
  assign ctx_path   = ctx_q[cell_conn] & cfg_ovh_en & cfg_ctx_sel_ing & !cell_egress;
  assign ing_status = cfg_glb_ing_mark | ifs_path | ctx_path;
  assign egr_status = cfg_glb_egr_mark | (ovh_efs & cfg_efs_en & cell_egress);

  assign mark_brm  = cell_egress  && cell_type == 2'b10 && cfg_brm_mark_en && ing_status;
  assign mark_frm  = !cell_egress && cell_type == 2'b01 && cfg_frm_mark_en && ing_status;
  assign mark_rm   = is_rm_pti && (mark_brm || mark_frm);
  assign mark_efci = is_user && cfg_efci_en &&
                     (cell_egress ? egr_status : ing_status);

  always_comb begin
    rm_set = '0;
    rm_set[CI_BIT] = cfg_set_ci;
    rm_set[NI_BIT] = cfg_set_ni;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q   <= '0;
      out_vld <= 1'b0;
      out_hdr <= '0;
      out_rmb <= '0;
    end else begin
      out_vld <= cell_vld;
      if (cell_vld) begin
        out_hdr <= cell_hdr | {29'd0, mark_efci, 2'b00};
        out_rmb <= cell_rmb | (mark_rm ? rm_set : 8'h00);
        if (cell_egress && cfg_ovh_en)
          ctx_q[cell_conn] <= ovh_ifs;
      end
    end
  end

endmodule

// File: rtl/atm_flow_marker_chk.sv
module atm_flow_marker_chk #(
  parameter int CI_BIT = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cell_vld,
  input logic        cell_egress,
  input logic [1:0]  cell_type,
  input logic [31:0] cell_hdr,
  input logic [7:0]  cell_rmb,
  input logic        cfg_glb_ing_mark,
  input logic        cfg_frm_mark_en,
  input logic        cfg_set_ci,
  input logic        out_vld,
  input logic [31:0] out_hdr,
  input logic [7:0]  out_rmb
);

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_vld |=> out_vld);

  p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_vld |=> !out_vld);

  p_iame_frm_ci_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && !cell_egress && cfg_glb_ing_mark && cfg_frm_mark_en && cfg_set_ci &&
     cell_type == 2'b01 && cell_hdr[3:1] == 3'b110) |=> out_rmb[CI_BIT]);

  p_hdr_only_efci_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_vld |=> ((out_hdr ^ $past(cell_hdr)) & ~32'h4) == 32'h0);

  p_nonuser_hdr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && cell_hdr[3]) |=> out_hdr == $past(cell_hdr));

  p_non_rm_byte_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && cell_hdr[3:1] != 3'b110) |=> out_rmb == $past(cell_rmb));

  p_byte_set_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_vld |=> (out_rmb & $past(cell_rmb)) == $past(cell_rmb));

endmodule

bind atm_flow_marker atm_flow_marker_chk #(.CI_BIT(CI_BIT)) u_chk (.*);

// File: tb/test_atm_flow_marker.sv
module test_atm_flow_marker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cell_vld = 0, cell_egress = 0;
  logic [1:0]  cell_type = 0;
  logic [3:0]  cell_conn = 0;
  logic [31:0] cell_hdr = 0, cell_ovh = 0;
  logic [7:0]  cell_rmb = 0;
  logic [10:0] cfg = 0;
  logic [1:0]  ifs_byte = 0, efs_byte = 0;
  logic [2:0]  ifs_bit = 0, efs_bit = 0;
  logic        out_vld;
  logic [31:0] out_hdr;
  logic [7:0]  out_rmb;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  atm_flow_marker i_atm_flow_marker (
    .clk, .rst_n, .cell_vld, .cell_egress, .cell_type, .cell_conn,
    .cell_hdr, .cell_ovh, .cell_rmb,
    .cfg_glb_ing_mark(cfg[10]), .cfg_ovh_en(cfg[9]), .cfg_ovh_sel_egr(cfg[8]),
    .cfg_ctx_sel_ing(cfg[7]), .cfg_glb_egr_mark(cfg[6]), .cfg_efs_en(cfg[5]),
    .cfg_brm_mark_en(cfg[4]), .cfg_frm_mark_en(cfg[3]), .cfg_efci_en(cfg[2]),
    .cfg_set_ci(cfg[1]), .cfg_set_ni(cfg[0]),
    .cfg_ifs_byte(ifs_byte), .cfg_ifs_bit(ifs_bit),
    .cfg_efs_byte(efs_byte), .cfg_efs_bit(efs_bit),
    .out_vld, .out_hdr, .out_rmb
  );

  localparam logic [10:0] C_IAME = 11'h400, C_OVH = 11'h200, C_SEGR = 11'h100,
                          C_SING = 11'h080, C_EAME = 11'h040, C_EFS = 11'h020,
                          C_BRM  = 11'h010, C_FRM = 11'h008, C_EFCI = 11'h004,
                          C_CI   = 11'h002, C_NI  = 11'h001;
  localparam logic [31:0] H  = 32'h0ABC_D000;
  localparam logic [31:0] RM = H | 32'hC;

  typedef struct packed {
    logic [3:0]  req;
    logic        egr;
    logic [1:0]  typ;
    logic [31:0] hdr;
    logic [31:0] ovh;
    logic [7:0]  rmb;
    logic [10:0] cfg;
    logic [1:0]  ib;
    logic [2:0]  ibit;
    logic [1:0]  eb;
    logic [2:0]  ebit;
    logic [31:0] exp_hdr;
    logic [7:0]  exp_rmb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  1'b0, 2'b01, RM, 32'h0, 8'h00, C_IAME|C_FRM|C_CI, 2'd0, 3'd0, 2'd0, 3'd0, RM, 8'h40},              // R3 CI
    '{4'd3,  1'b0, 2'b01, RM, 32'h0, 8'h01, C_IAME|C_FRM|C_NI, 2'd0, 3'd0, 2'd0, 3'd0, RM, 8'h21},              // R3 NI
    '{4'd4,  1'b1, 2'b10, RM, 32'h0020_0000, 8'h00, C_OVH|C_SEGR|C_BRM|C_CI, 2'd2, 3'd5, 2'd0, 3'd0, RM, 8'h40}, // R4 hit
    '{4'd4,  1'b1, 2'b10, RM, 32'h0000_2000, 8'h00, C_OVH|C_SEGR|C_BRM|C_CI, 2'd2, 3'd5, 2'd0, 3'd0, RM, 8'h00}, // R4 other byte
    '{4'd4,  1'b1, 2'b10, RM, 32'h0040_0000, 8'h00, C_OVH|C_SEGR|C_BRM|C_CI, 2'd2, 3'd5, 2'd0, 3'd0, RM, 8'h00}, // R4 other bit
    '{4'd4,  1'b0, 2'b10, RM, 32'h0020_0000, 8'h00, C_OVH|C_SEGR|C_BRM|C_CI, 2'd2, 3'd5, 2'd0, 3'd0, RM, 8'h00}, // R4 ingress
    '{4'd11, 1'b1, 2'b10, RM, 32'h0020_0000, 8'h00, C_SEGR|C_BRM|C_CI, 2'd2, 3'd5, 2'd0, 3'd0, RM, 8'h00},       // R11
    '{4'd8,  1'b0, 2'b01, H|32'hE, 32'h0, 8'h00, C_IAME|C_FRM|C_CI, 2'd0, 3'd0, 2'd0, 3'd0, H|32'hE, 8'h00},    // R8
    '{4'd7,  1'b0, 2'b00, H, 32'h0, 8'h00, C_IAME|C_EFCI, 2'd0, 3'd0, 2'd0, 3'd0, H|32'h4, 8'h00},               // R7 user
    '{4'd7,  1'b0, 2'b00, H|32'h8, 32'h0, 8'h00, C_IAME|C_EFCI, 2'd0, 3'd0, 2'd0, 3'd0, H|32'h8, 8'h00},         // R7 non-user
    '{4'd10, 1'b1, 2'b00, H, 32'h0, 8'h00, C_EAME|C_EFCI, 2'd0, 3'd0, 2'd0, 3'd0, H|32'h4, 8'h00},               // R10 global
    '{4'd10, 1'b1, 2'b00, H, 32'h0100_0000, 8'h00, C_EFS|C_EFCI, 2'd0, 3'd0, 2'd3, 3'd0, H|32'h4, 8'h00},        // R10 bit
    '{4'd9,  1'b0, 2'b01, RM, 32'h0, 8'h60, C_IAME|C_FRM|C_CI, 2'd0, 3'd0, 2'd0, 3'd0, RM, 8'h60}                // R9
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic egr, input logic [1:0] typ, input logic [3:0] conn,
                      input logic [31:0] hdr, input logic [31:0] ovh, input logic [7:0] rmb);
    @(negedge clk);
    cell_vld = 1; cell_egress = egr; cell_type = typ; cell_conn = conn;
    cell_hdr = hdr; cell_ovh = ovh; cell_rmb = rmb;
    @(negedge clk);
    cell_vld = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cfg = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values
    check(1, "out_vld after reset", {31'd0, out_vld}, 0);
    check(1, "out_hdr after reset", out_hdr, 0);
    check(1, "out_rmb after reset", {24'd0, out_rmb}, 0);

    // R2: one-cycle latency
    send(1'b0, 2'b00, 4'd0, 32'h1357_9BD0, 32'h0, 8'h5A);
    check(2, "out_vld one cycle later", {31'd0, out_vld}, 1);
    check(2, "out_hdr passes", out_hdr, 32'h1357_9BD0);
    @(negedge clk);
    check(2, "out_vld drops", {31'd0, out_vld}, 0);

    for (int i = 0; i < NV; i++) begin
      cfg = TBL[i].cfg; ifs_byte = TBL[i].ib; ifs_bit = TBL[i].ibit;
      efs_byte = TBL[i].eb; efs_bit = TBL[i].ebit;
      send(TBL[i].egr, TBL[i].typ, 4'd15, TBL[i].hdr, TBL[i].ovh, TBL[i].rmb);
      check(TBL[i].req, $sformatf("row %0d hdr", i), out_hdr, TBL[i].exp_hdr);
      check(TBL[i].req, $sformatf("row %0d rmb", i), {24'd0, out_rmb}, {24'd0, TBL[i].exp_rmb});
    end

    // R10: egress status bit at a non-selected position
    cfg = C_EFS | C_EFCI; efs_byte = 2'd3; efs_bit = 3'd0;
    send(1'b1, 2'b00, 4'd15, H, 32'h0000_0001, 8'h00);
    check(10, "efs wrong position", out_hdr, H);

    // context tests from a clean reset
    do_reset();
    ifs_byte = 2'd0; ifs_bit = 3'd0;
    cfg = C_OVH | C_SING | C_FRM | C_CI;
    send(1'b0, 2'b01, 4'd3, RM, 32'h0, 8'h00);
    check(1, "context cleared by reset", {24'd0, out_rmb}, 0);
    send(1'b1, 2'b00, 4'd3, H, 32'h1, 8'h00);              // R5 write
    send(1'b0, 2'b01, 4'd3, RM, 32'h0, 8'h00);
    check(5, "stored bit marks FRM", {24'd0, out_rmb}, 32'h40);
    send(1'b0, 2'b01, 4'd4, RM, 32'h0, 8'h00);
    check(5, "neighbour connection unmarked", {24'd0, out_rmb}, 0);
    cfg = C_SING | C_FRM | C_CI;
    send(1'b0, 2'b01, 4'd3, RM, 32'h0, 8'h00);
    check(11, "stored bit ignored without ovh enable", {24'd0, out_rmb}, 0);
    cfg = C_OVH | C_SING | C_FRM | C_CI;
    send(1'b1, 2'b00, 4'd3, H, 32'h0, 8'h00);              // R6 clear
    send(1'b0, 2'b01, 4'd3, RM, 32'h0, 8'h00);
    check(6, "stored bit cleared", {24'd0, out_rmb}, 0);
    cfg = C_SING | C_FRM | C_CI;
    send(1'b1, 2'b00, 4'd5, H, 32'h1, 8'h00);              // R11 no update
    cfg = C_OVH | C_SING | C_FRM | C_CI;
    send(1'b0, 2'b01, 4'd5, RM, 32'h0, 8'h00);
    check(11, "no context update without ovh enable", {24'd0, out_rmb}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule